// File: doc/BRIEF.md
# Synchronous SRAM Sleep-Mode Controller

This block sits in front of a synchronous SRAM and governs its low-power sleep state. An asynchronous, active-high sleep request is brought into the clock domain by a synchroniser chain. The controller then walks through a fixed entry latency, a sleep phase and a fixed exit latency. A recovery window follows, and only after it are new accesses accepted again. Stored data is kept safe because no access is accepted at any point outside the normal run phase.

While the controller is anywhere other than the run phase, it tells the data path to keep the bus at high impedance. It also turns every new access request into a rejection. An access that is pending or being presented at the moment sleep is entered is thrown away, and a one-cycle pulse reports this. Software or a system controller is expected to deselect the memory before it raises the request. If the memory is still selected on the entry edge, an error flag is raised and held until the controller is ready again.

The entry, exit and recovery lengths are parameters, and so is the depth of the synchroniser.

Top module: `sleep_ctrl`

## Requirements
- R1: A request that is high before a rising edge is registered through a two-stage synchroniser. `ready_o` falls after the third rising edge counted from that edge.
- R2: `sleep_o` rises exactly two clock cycles after `ready_o` falls. This is the entry latency, and entry always completes once it has started.
- R3: After the request goes low, `sleep_o` falls after the third rising edge. The exit phase that follows lasts two cycles.
- R4: `hiz_o` is high in every cycle in which `ready_o` is low, through entry, sleep, exit and recovery. It is low while `ready_o` is high.
- R5: `ready_o` rises 2 + RECOVERY_CYCLES clock cycles after `sleep_o` falls.
- R6: `accept_o` equals `cs_i & astb_i & ready_o`. `reject_o` equals `cs_i & astb_i & !ready_o`. Both respond within the same cycle.
- R7: `drop_o` is high for exactly the first entry cycle when, on the entry edge, `busy_i` was high or `cs_i & astb_i` was high. Otherwise it stays low.
- R8: `err_o` is set on the entry edge if `cs_i` was high then. It stays high until the edge on which `ready_o` returns high, and at that edge it clears.
- R9: A request that drops while entry is already under way still completes entry. It then gives exactly one cycle of `sleep_o` before exit begins.
- R10: A request raised during exit or recovery does not shorten the recovery window. `ready_o` is then high for exactly one cycle before the next entry starts.
- R11: After reset, `ready_o` is high and `sleep_o`, `hiz_o`, `drop_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| cs_i | input | 1 | Memory currently selected |
| astb_i | input | 1 | Address strobe: a new access is presented |
| busy_i | input | 1 | An access is pending in the memory pipeline |
| sleep_o | output | 1 | Sleep state is active |
| hiz_o | output | 1 | Force the data bus to high impedance |
| ready_o | output | 1 | Normal accesses may be accepted |
| accept_o | output | 1 | The presented access is accepted |
| reject_o | output | 1 | The presented access is refused |
| drop_o | output | 1 | A pending or presented access was discarded on entry |
| err_o | output | 1 | Sleep was requested while the memory was selected |

## Verification
Directed sequences measure the number of edges between each request transition and the `ready_o` and `sleep_o` changes. These counts separate the synchroniser delay, the entry latency, the exit latency and the recovery length from one another. Short requests and requests raised during recovery show whether the phases finish in order or get cut short. A deliberately selected, busy memory on the entry edge exercises the discard pulse and the error flag. Seeded random request, select, strobe and busy traffic is then compared cycle by cycle against a phase-counting model in the bench. This catches overlaps between these cases that the directed sequences do not reach.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [2:0] {
      PH_RUN     = 3'd0,
      PH_ENTER   = 3'd1,
      PH_SLEEP   = 3'd2,
      PH_EXIT    = 3'd3,
      PH_RECOVER = 3'd4
   } phase_e;

   function automatic int cnt_bits(input int maxval);
      int b;
      b = $clog2(maxval + 1);
      return (b < 1) ? 1 : b;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain <= '0;
            else         chain <= {chain[0], d_i};
         end
      end else begin : g_deep
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain <= '0;
            else         chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

   // R1: the output only ever takes the value the previous stage held
   p_sync_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(q_o) |-> (q_o == $past(chain[STAGES-2])));

endmodule

// File: rtl/slp_timer.sv
module slp_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (load_i)      cnt_q <= val_i;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   p_timer_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_q) != '0 && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
   import slp_pkg::*;
#(
   parameter int ENTRY_CYCLES    = 2,
   parameter int EXIT_CYCLES     = 2,
   parameter int RECOVERY_CYCLES = 4,
   parameter int CNT_W           = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_s_i,
   input  logic             cs_i,
   input  logic             astb_i,
   input  logic             busy_i,
   input  logic             done_i,
   output logic             load_o,
   output logic [CNT_W-1:0] val_o,
   output phase_e           phase_o,
   output logic             drop_o,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] ENT_LD = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXT_LD = CNT_W'(EXIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'(RECOVERY_CYCLES - 1);

   phase_e ph_q, ph_d;
   logic   entry_edge, recover_end;

   assign entry_edge  = (ph_q == PH_RUN) && req_s_i;
   assign recover_end = (ph_q == PH_RECOVER) && done_i;

   always_comb begin
      ph_d   = ph_q;
      load_o = 1'b0;
      val_o  = '0;
      unique case (ph_q)
         PH_RUN: if (req_s_i) begin
            ph_d = PH_ENTER; load_o = 1'b1; val_o = ENT_LD;
         end
         PH_ENTER: if (done_i) ph_d = PH_SLEEP;
         PH_SLEEP: if (!req_s_i) begin
            ph_d = PH_EXIT; load_o = 1'b1; val_o = EXT_LD;
         end
         PH_EXIT: if (done_i) begin
            ph_d = PH_RECOVER; load_o = 1'b1; val_o = REC_LD;
         end
         PH_RECOVER: if (done_i) ph_d = PH_RUN;
         default: ph_d = PH_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_RUN;
         drop_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         drop_o <= entry_edge && (busy_i || (cs_i && astb_i));
         if (entry_edge && cs_i) err_o <= 1'b1;
         else if (recover_end)   err_o <= 1'b0;
      end
   end

   assign phase_o = ph_q;

   // checker counter: cycles spent in the recovery phase
   logic [CNT_W:0] rec_seen;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 rec_seen <= '0;
      else if (ph_q != PH_RECOVER) rec_seen <= '0;
      else                         rec_seen <= rec_seen + 1'b1;
   end

   p_entry_two_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_SLEEP && $past(ph_q) != PH_SLEEP) |->
         ($past(ph_q) == PH_ENTER && $past(ph_q, 2) == PH_ENTER));

   p_exit_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_EXIT && $past(ph_q) == PH_SLEEP) |-> !$past(req_s_i));

   p_recover_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_RUN && $past(ph_q) == PH_RECOVER) |->
         (rec_seen == (CNT_W+1)'(RECOVERY_CYCLES)));

   p_drop_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_o |=> !drop_o);

   p_err_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> ($past(cs_i) && $past(ph_q) == PH_RUN));

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int ENTRY_CYCLES    = 2,
   parameter int EXIT_CYCLES     = 2,
   parameter int RECOVERY_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_req_i,
   input  logic cs_i,
   input  logic astb_i,
   input  logic busy_i,
   output logic sleep_o,
   output logic hiz_o,
   output logic ready_o,
   output logic accept_o,
   output logic reject_o,
   output logic drop_o,
   output logic err_o
);

   localparam int MAXV  = max3(ENTRY_CYCLES, EXIT_CYCLES, RECOVERY_CYCLES);
   localparam int CNT_W = cnt_bits(MAXV);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ENTRY_CYCLES < 1 || EXIT_CYCLES < 1) begin : g_bad_lat
         $error("entry and exit latencies must be at least 1");
      end
      if (RECOVERY_CYCLES < 1) begin : g_bad_rec
         $error("RECOVERY_CYCLES must be at least 1");
      end
   endgenerate

   logic             req_s, t_load, t_done;
   logic [CNT_W-1:0] t_val;
   phase_e           phase;

   slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sleep_req_i), .q_o(req_s)
   );

   slp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load), .val_i(t_val),
      .done_o(t_done)
   );

   slp_fsm #(
      .ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES),
      .RECOVERY_CYCLES(RECOVERY_CYCLES), .CNT_W(CNT_W)
   ) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_s_i(req_s), .cs_i(cs_i),
      .astb_i(astb_i), .busy_i(busy_i), .done_i(t_done), .load_o(t_load),
      .val_o(t_val), .phase_o(phase), .drop_o(drop_o), .err_o(err_o)
   );

   assign ready_o  = (phase == PH_RUN);
   assign sleep_o  = (phase == PH_SLEEP);
   assign hiz_o    = !ready_o;
   assign accept_o = cs_i && astb_i && ready_o;
   assign reject_o = cs_i && astb_i && !ready_o;

   p_sleep_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_o |-> (hiz_o && !accept_o));

endmodule

// File: tb/tb_sleep_ctrl.sv
module tb_sleep_ctrl;
   localparam int ENT = 2, EXT = 2, REC = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, cs = 1'b0, astb = 1'b0, busy = 1'b0;
   logic sleep_o, hiz_o, ready_o, accept_o, reject_o, drop_o, err_o;
   int   n_chk = 0, n_err = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   sleep_ctrl #(.SYNC_STAGES(2), .ENTRY_CYCLES(ENT), .EXIT_CYCLES(EXT),
                .RECOVERY_CYCLES(REC)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .cs_i(cs),
      .astb_i(astb), .busy_i(busy), .sleep_o(sleep_o), .hiz_o(hiz_o),
      .ready_o(ready_o), .accept_o(accept_o), .reject_o(reject_o),
      .drop_o(drop_o), .err_o(err_o)
   );

   // phase-counting reference model: 0 run,1 enter,2 sleep,3 exit,4 recover
   logic m_s1, m_s2, m_drop, m_err;
   int   m_ph, m_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_drop <= 0; m_err <= 0; m_ph <= 0; m_cnt <= 0;
      end else begin
         m_s1 <= req; m_s2 <= m_s1; m_drop <= 1'b0;
         case (m_ph)
            0: if (m_s2) begin
                  m_ph <= 1; m_cnt <= ENT;
                  m_drop <= busy | (cs & astb);
                  if (cs) m_err <= 1'b1;
               end
            1: if (m_cnt == 1) m_ph <= 2; else m_cnt <= m_cnt - 1;
            2: if (!m_s2) begin m_ph <= 3; m_cnt <= EXT; end
            3: if (m_cnt == 1) begin m_ph <= 4; m_cnt <= REC; end
               else m_cnt <= m_cnt - 1;
            default: if (m_cnt == 1) begin m_ph <= 0; m_err <= 1'b0; end
               else m_cnt <= m_cnt - 1;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic sig(input int w);
      return (w == 0) ? ready_o : sleep_o;
   endfunction

   task automatic wait_for(input int w, input logic v, output int n);
      n = 0;
      do begin
         @(posedge clk); @(negedge clk); n++;
      end while (sig(w) !== v && n < 200);
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 ready", ready_o, 1); chk("R11 sleep", sleep_o, 0);
      chk("R11 hiz", hiz_o, 0);     chk("R11 drop", drop_o, 0);
      chk("R11 err", err_o, 0);
      // R6 accept while running
      cs = 1; astb = 1; #1;
      chk("R6 accept run", accept_o, 1); chk("R6 reject run", reject_o, 0);
      cs = 0; astb = 0;

      // R1/R2 entry timing
      req = 1;
      wait_for(0, 1'b0, n); chk("R1 edges to ready low", n, 3);
      chk("R4 hiz in entry", hiz_o, 1);
      chk("R7 no drop when idle", drop_o, 0);
      wait_for(1, 1'b1, n); chk("R2 entry cycles", n, ENT);
      cs = 1; astb = 1; #1;
      chk("R6 accept sleep", accept_o, 0); chk("R6 reject sleep", reject_o, 1);
      cs = 0; astb = 0;
      // R3/R5 exit and recovery
      req = 0;
      wait_for(1, 1'b0, n); chk("R3 edges to sleep low", n, 3);
      chk("R4 hiz in exit", hiz_o, 1);
      wait_for(0, 1'b1, n); chk("R5 recovery edges", n, EXT + REC);
      chk("R4 hiz off in run", hiz_o, 0);

      // R7/R8 entry while selected and busy
      cs = 1; astb = 1; busy = 1; req = 1;
      cyc(); cyc(); cyc();
      chk("R7 drop pulse", drop_o, 1); chk("R8 err set", err_o, 1);
      cs = 0; astb = 0; busy = 0;
      cyc(); chk("R7 drop one cycle", drop_o, 0);
      wait_for(1, 1'b1, n);
      req = 0;
      wait_for(1, 1'b0, n); chk("R8 err held", err_o, 1);
      wait_for(0, 1'b1, n); chk("R8 err cleared", err_o, 0);

      // R9 short request
      req = 1; cyc(); cyc(); cyc(); req = 0;
      wait_for(1, 1'b1, n);
      n = 0;
      while (sleep_o === 1'b1 && n < 50) begin cyc(); n++; end
      chk("R9 sleep cycles", n, 1);
      wait_for(0, 1'b1, n);

      // R10 request during recovery
      req = 1;
      wait_for(1, 1'b1, n);
      req = 0;
      wait_for(1, 1'b0, n);
      req = 1;
      wait_for(0, 1'b1, n); chk("R10 recovery not shortened", n, EXT + REC);
      cyc(); chk("R10 ready one cycle", ready_o, 0);
      req = 0;
      wait_for(0, 1'b1, n);

      // random traffic compared against the model
      for (int i = 0; i < 4000; i++) begin
         chk("R4 rnd hiz", hiz_o, m_ph != 0);
         chk("R1 rnd ready", ready_o, m_ph == 0);
         chk("R2 rnd sleep", sleep_o, m_ph == 2);
         chk("R6 rnd accept", accept_o, (m_ph == 0) & cs & astb);
         chk("R6 rnd reject", reject_o, (m_ph != 0) & cs & astb);
         chk("R7 rnd drop", drop_o, m_drop);
         chk("R8 rnd err", err_o, m_err);
         if ($urandom_range(0, 29) == 0) req = ~req;
         cs   = ($urandom_range(0, 9) < 3);
         astb = $urandom_range(0, 1);
         busy = ($urandom_range(0, 9) < 3);
         cyc();
      end
      done = 1'b1;
      summary();
   end
endmodule